// File: doc/BRIEF.md
# Multithreaded Register File with Constant Operands

This block holds the general-purpose registers of a small multithreaded processor core. Every hardware thread has its own bank of 24 writable 32-bit registers. A thread-number input picks the bank that all three ports use in a given cycle. The 5-bit operand index space also holds eight read-only sources. Four of them are fixed constants. The other four are the current thread number scaled by 1, 2, 4 and 8, so software can form per-thread offsets without first loading a value.

There are two combinational read ports and one write port. Each port has its own wide flag. When the flag is set, the port treats its index as a 64-bit pair made of an even register and the odd register after it. The even register carries the upper 32 bits of the pair. A pair request that names an odd index or a read-only index is illegal. On a read port it raises that port's error flag and returns zero. On the write port it raises the write error flag and changes no register.

Top module: `mt_regfile`

## Requirements
- R1: Reset clears every writable register in every bank to zero.
- R2: A 32-bit read with index 0..23 returns the selected register of bank `tid` on bits 31:0, with bits 63:32 zero and the error flag low.
- R3: A 32-bit read of index 24 returns 0. Index 25 returns 1. Index 26 returns 0xFFFFFFFF. Index 27 returns 0x80000000.
- R4: A 32-bit read of index 28, 29, 30 or 31 returns `tid` multiplied by 1, 2, 4 or 8 respectively.
- R5: A 32-bit write with index 0..23 stores `wdata[31:0]` at the clock edge, and the new value is readable in the following cycle.
- R6: A 32-bit write aimed at index 24..31 is ignored and does not raise `w_err`. The constant operands keep their values and no register changes.
- R7: A wide read with an even index below 24 returns the even register on bits 63:32 and the next odd register on bits 31:0.
- R8: A wide read with an odd index, or with an index of 24 or more, raises that port's error flag and returns all zeros.
- R9: A legal wide write updates both registers of the pair at the same clock edge. The even register takes `wdata[63:32]` and the odd register takes `wdata[31:0]`.
- R10: An illegal wide write raises `w_err` in the cycle it is presented and modifies no register.
- R11: A read in the same cycle as a write to the same register returns the value held before that write.
- R12: A write in one thread's bank never changes a register seen by another thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid | input | $clog2(NTHREADS) | Thread number selecting the bank |
| ra_sel | input | 5 | Read port A index |
| ra_wide | input | 1 | Read port A 64-bit pair mode |
| rb_sel | input | 5 | Read port B index |
| rb_wide | input | 1 | Read port B 64-bit pair mode |
| we | input | 1 | Write enable |
| wsel | input | 5 | Write index |
| wwide | input | 1 | Write 64-bit pair mode |
| wdata | input | 64 | Write data (bits 31:0 in 32-bit mode) |
| ra_data | output | 64 | Read port A data |
| ra_err | output | 1 | Read port A illegal pair request |
| rb_data | output | 64 | Read port B data |
| rb_err | output | 1 | Read port B illegal pair request |
| w_err | output | 1 | Illegal pair write request |

## Verification
Read data and both read error flags are combinational and belong to the cycle in which the operands are presented. `w_err` is also due in that same cycle. A write shows up on the read ports only in the cycle after its clock edge. The driver presents every operation just after a falling edge and pushes the expected item, computed from a shadow register model that reflects all writes up to that edge. The monitor pops the item one nanosecond later, before the next rising edge, so every comparison sees the state before the pending write. That is exactly the read-before-write case.

// File: rtl/mt_regfile.sv
module mt_regfile #(
  parameter int NTHREADS = 8,
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tid,
  input  logic [4:0]    ra_sel,
  input  logic          ra_wide,
  input  logic [4:0]    rb_sel,
  input  logic          rb_wide,
  input  logic          we,
  input  logic [4:0]    wsel,
  input  logic          wwide,
  input  logic [63:0]   wdata,
  output logic [63:0]   ra_data,
  output logic          ra_err,
  output logic [63:0]   rb_data,
  output logic          rb_err,
  output logic          w_err
);
  localparam int NREG  = 24;
  localparam int NSLOT = NTHREADS * NREG;
  localparam int AW    = $clog2(NSLOT + 1);
  localparam logic [4:0] RO_BASE = 5'(NREG);

  logic [31:0] rf [NSLOT];

  function automatic logic [64:0] rd(input logic [4:0] s, input logic w, input logic [TW-1:0] t);
    logic [AW-1:0] base;
    logic [63:0] d;
    logic e;
    base = AW'(t) * AW'(NREG);
    d = '0;
    e = 1'b0;
    if (w) begin
      if (s[0] || s >= RO_BASE) e = 1'b1;
      else d = {rf[base + AW'(s)], rf[base + AW'(s) + AW'(1)]};
    end else if (s < RO_BASE) begin
      d = {32'b0, rf[base + AW'(s)]};
    end else begin
      case (s[2:0])
        3'd0: d = 64'd0;
        3'd1: d = 64'd1;
        3'd2: d = {32'b0, 32'hFFFF_FFFF};
        3'd3: d = {32'b0, 32'h8000_0000};
        3'd4: d = {32'b0, 32'(t)};
        3'd5: d = {32'b0, 32'(t) << 1};
        3'd6: d = {32'b0, 32'(t) << 2};
        default: d = {32'b0, 32'(t) << 3};
      endcase
    end
    return {e, d};
  endfunction

  assign {ra_err, ra_data} = rd(ra_sel, ra_wide, tid);
  assign {rb_err, rb_data} = rd(rb_sel, rb_wide, tid);

  logic          pair_ok, wr_narrow, wr_pair;
  logic [AW-1:0] widx;

  assign pair_ok   = !wsel[0] && (wsel < RO_BASE);
  assign wr_narrow = we && !wwide && (wsel < RO_BASE);
  assign wr_pair   = we && wwide && pair_ok;
  assign w_err     = we && wwide && !pair_ok;
  assign widx      = AW'(tid) * AW'(NREG) + AW'(wsel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) rf[i] <= '0;
    end else if (wr_pair) begin
      rf[widx]         <= wdata[63:32];
      rf[widx + AW'(1)] <= wdata[31:0];
    end else if (wr_narrow) begin
      rf[widx] <= wdata[31:0];
    end
  end
endmodule

module mt_regfile_chk #(
  parameter int NTHREADS = 8,
  localparam int TW = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] tid,
  input logic [4:0]    ra_sel,
  input logic          ra_wide,
  input logic          we,
  input logic [4:0]    wsel,
  input logic          wwide,
  input logic [63:0]   wdata,
  input logic [63:0]   ra_data,
  input logic          ra_err,
  input logic          w_err
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R3
  c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_wide && ra_sel == 5'd24) |-> ra_data == 64'd0);
  // R3
  c_lneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_wide && ra_sel == 5'd26) |-> ra_data == 64'h0000_0000_FFFF_FFFF);
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ra_err |-> ra_data == 64'd0);
  // R8
  ro_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_wide && ra_sel >= 5'd24) |-> ra_err);
  // R5
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(we && !wwide && wsel < 5'd24) && !ra_wide && ra_sel == $past(wsel) && tid == $past(tid))
      |-> ra_data == {32'b0, $past(wdata[31:0])});
  // R9
  pair_wr_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    ($past(we && wwide && !wsel[0] && wsel < 5'd24) && ra_wide && ra_sel == $past(wsel) && tid == $past(tid))
      |-> ra_data == $past(wdata));
  // R10
  w_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || !wwide) |-> !w_err);
endmodule

bind mt_regfile mt_regfile_chk #(.NTHREADS(NTHREADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tid(tid), .ra_sel(ra_sel), .ra_wide(ra_wide),
  .we(we), .wsel(wsel), .wwide(wwide), .wdata(wdata),
  .ra_data(ra_data), .ra_err(ra_err), .w_err(w_err)
);

// File: tb/tb_mt_regfile.sv
module tb_mt_regfile;
  localparam int NT = 8;
  localparam int TW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] tid = '0;
  logic [4:0] ra_sel = '0, rb_sel = '0, wsel = '0;
  logic ra_wide = 1'b0, rb_wide = 1'b0, we = 1'b0, wwide = 1'b0;
  logic [63:0] wdata = '0;
  logic [63:0] ra_data, rb_data;
  logic ra_err, rb_err, w_err;

  always #2 clk = ~clk;

  mt_regfile #(.NTHREADS(NT)) dut (
    .clk(clk), .rst_n(rst_n), .tid(tid), .ra_sel(ra_sel), .ra_wide(ra_wide),
    .rb_sel(rb_sel), .rb_wide(rb_wide), .we(we), .wsel(wsel), .wwide(wwide),
    .wdata(wdata), .ra_data(ra_data), .ra_err(ra_err), .rb_data(rb_data),
    .rb_err(rb_err), .w_err(w_err)
  );

  typedef struct {
    logic [63:0] a; logic ae; logic [63:0] b; logic be; logic we_err; string tag;
  } item_t;

  item_t q[$];
  logic [31:0] mdl [NT][24];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic void mread(input int t, input logic [4:0] s, input logic w,
                                output logic [63:0] d, output logic e);
    d = '0; e = 1'b0;
    if (w) begin
      if (s[0] || s >= 5'd24) e = 1'b1;
      else d = {mdl[t][s], mdl[t][s+1]};
    end else if (s < 5'd24) d = {32'b0, mdl[t][s]};
    else begin
      case (s)
        5'd24: d = 0;
        5'd25: d = 1;
        5'd26: d = 64'hFFFF_FFFF;
        5'd27: d = 64'h8000_0000;
        5'd28: d = 64'(t);
        5'd29: d = 64'(t * 2);
        5'd30: d = 64'(t * 4);
        default: d = 64'(t * 8);
      endcase
    end
  endfunction

  task automatic op(input int t, input logic [4:0] as, input logic aw,
                    input logic [4:0] bs, input logic bw,
                    input logic w, input logic [4:0] ws, input logic ww,
                    input logic [63:0] wd, input string tag);
    item_t it;
    @(negedge clk);
    tid = TW'(t); ra_sel = as; ra_wide = aw; rb_sel = bs; rb_wide = bw;
    we = w; wsel = ws; wwide = ww; wdata = wd;
    mread(t, as, aw, it.a, it.ae);
    mread(t, bs, bw, it.b, it.be);
    it.we_err = w && ww && (ws[0] || ws >= 5'd24);
    it.tag = tag;
    q.push_back(it);
    if (w && !ww && ws < 5'd24) mdl[t][ws] = wd[31:0];
    if (w && ww && !ws[0] && ws < 5'd24) begin
      mdl[t][ws] = wd[63:32];
      mdl[t][ws+1] = wd[31:0];
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (ra_data !== it.a || ra_err !== it.ae || rb_data !== it.b ||
            rb_err !== it.be || w_err !== it.we_err) begin
          fails++;
          $display("FAIL %s: got a=%h/%b b=%h/%b werr=%b exp a=%h/%b b=%h/%b werr=%b",
                   it.tag, ra_data, ra_err, rb_data, rb_err, w_err,
                   it.a, it.ae, it.b, it.be, it.we_err);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) for (int r = 0; r < 24; r++) mdl[t][r] = 32'hDEAD_BEEF;
    // dirty some registers before reset
    rst_n = 1'b1;
    @(negedge clk); we = 1; wsel = 5; wdata = 64'h1234; tid = 3;
    @(negedge clk); we = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < NT; t++) for (int r = 0; r < 24; r++) mdl[t][r] = '0;

    op(3, 5, 0, 23, 0, 0, 0, 0, 0, "R1 reset clears");
    op(7, 0, 1, 22, 1, 0, 0, 0, 0, "R1 reset clears pairs");
    op(2, 24, 0, 25, 0, 0, 0, 0, 0, "R3 zero/one");
    op(2, 26, 0, 27, 0, 0, 0, 0, 0, "R3 lneg/mneg");
    op(5, 28, 0, 29, 0, 0, 0, 0, 0, "R4 id/id2");
    op(5, 30, 0, 31, 0, 0, 0, 0, 0, "R4 id4/id8");
    op(7, 31, 0, 30, 0, 0, 0, 0, 0, "R4 max thread");
    op(1, 4, 0, 4, 0, 1, 4, 0, 64'hFFFF_FFFF_CAFE_F00D, "R11 old value on write");
    op(1, 4, 0, 3, 0, 0, 0, 0, 0, "R5 R2 narrow write visible");
    op(1, 26, 0, 4, 0, 1, 26, 0, 64'h55, "R6 write to constant");
    op(1, 26, 0, 4, 0, 0, 0, 0, 0, "R6 constant unchanged");
    op(1, 10, 1, 10, 0, 1, 10, 1, 64'hAAAA_0001_BBBB_0002, "R11 pair old value");
    op(1, 10, 1, 11, 0, 0, 0, 0, 0, "R9 R7 pair write both halves");
    op(1, 10, 0, 11, 1, 0, 0, 0, 0, "R8 odd pair read");
    op(1, 24, 1, 28, 1, 0, 0, 0, 0, "R8 read-only pair read");
    op(1, 2, 1, 4, 1, 1, 3, 1, 64'h1111_2222_3333_4444, "R10 odd pair write flagged");
    op(1, 2, 1, 4, 1, 0, 0, 0, 0, "R10 neighbours unchanged");
    op(1, 24, 1, 26, 0, 1, 24, 1, 64'h9, "R10 read-only pair write");
    op(1, 22, 1, 23, 0, 1, 22, 1, 64'h0102_0304_0506_0708, "R7 top pair write");
    op(1, 22, 1, 23, 0, 0, 0, 0, 0, "R7 top pair read");
    op(6, 4, 0, 10, 1, 1, 4, 0, 64'h77, "R12 other bank untouched");
    op(1, 4, 0, 10, 1, 0, 0, 0, 0, "R12 bank 1 kept");
    op(6, 4, 0, 5, 0, 0, 0, 0, 0, "R12 bank 6 own value");
    op(0, 0, 0, 29, 0, 0, 0, 0, 0, "R2 R4 thread zero");

    @(negedge clk); we = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule